// File: doc/BRIEF.md
# Acquisition Stop and Conversion Sequencer

This block runs the acquisition cycle of a four-channel waveform sampler. While armed it keeps the circular analog storage writing, and it advances a write pointer once per clock edge at which writing is enabled. When a stop condition arrives it freezes the storage, records where the pointer stood, asks the converters to start, and then waits until conversion is reported complete. At that point it flags the data as readable. It then stays frozen until software re-arms it.

The stop source depends on the mode input. In self-trigger mode, any one of the discriminator bits stops every channel together. The stop comes only after a programmable number of clock cycles, so that the pedestal before the pulse and the pulse itself both stay in storage. In external mode, the external trigger level gates writing directly: high samples and low holds. A low level also ends the acquisition at once. The discriminator bits are always passed out, registered, as per-channel trigger outputs. A delayed trigger pulse marks the moment a self-trigger delay runs out.

There are four states. `ST_WRITE` is armed and sampling. `ST_DELAY` is the post-trigger countdown while still sampling. `ST_CONVERT` is frozen and waiting for conversion to finish. `ST_READY` is frozen with the data readable. The transitions are:
- arm-hit: `ST_WRITE` to `ST_DELAY` on a discriminator hit in self mode.
- ext-stop: `ST_WRITE` to `ST_CONVERT` on a low external level in external mode.
- expire: `ST_DELAY` to `ST_CONVERT` when the countdown reaches zero.
- done: `ST_CONVERT` to `ST_READY` when conversion completes.
- rearm: `ST_READY` to `ST_WRITE`.

Top module: `acq_sequencer`

## Requirements
- R1: While reset is asserted, the block is armed in `ST_WRITE`. With the mode at 0, `sample_en_o` is 1. `data_ready_o`, `conv_start_o`, `trig_dly_o`, `trig_out_o` and `stop_ptr_o` are all 0.
- R2: With `ext_mode_i` = 0, a clock edge in `ST_WRITE` that sees any bit of `disc_i` high loads the delay value D from `delay_cfg_i`. `sample_en_o` then stays 1 for exactly D+1 further cycles and goes 0 in the cycle after that. D = 0 is valid and gives one extra cycle.
- R3: Discriminator activity is ignored in `ST_DELAY`, `ST_CONVERT` and `ST_READY`. It does not restart the delay, shift the stop, or change state.
- R4: With `ext_mode_i` = 1 in `ST_WRITE`, `sample_en_o` equals `ext_trig_i` in the same cycle. A clock edge that sees `ext_trig_i` = 0 moves the block straight to `ST_CONVERT`.
- R5: `conv_start_o` is a single-cycle pulse in the first cycle of `ST_CONVERT`, whichever source caused the stop. It is common to all channels.
- R6: `trig_dly_o` is a single-cycle pulse in the same cycle as `conv_start_o`, but only when the stop came from the self-trigger delay. It never pulses on an external stop.
- R7: `trig_out_o` equals `disc_i` as sampled on the previous clock edge, in every state and mode.
- R8: `data_ready_o` is 1 exactly while the block is in `ST_READY`. It is entered on the edge after `conv_done_i` is seen high in `ST_CONVERT`. `sample_en_o` is 0 throughout `ST_CONVERT` and `ST_READY`.
- R9: `rearm_i` seen high in `ST_READY` returns the block to `ST_WRITE` on that edge. In any other state `rearm_i` has no effect.
- R10: The write pointer starts at 0 and adds 1, modulo 2^PTR_W, at every edge where `sample_en_o` is 1. On entry to `ST_CONVERT`, `stop_ptr_o` takes the pointer value after the last write. It holds that value until the next stop.
- R11: In external mode, discriminator bits cause no stop and no delay. `sample_en_o` keeps following `ext_trig_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_i | input | NUM_CH | Per-channel discriminator hits |
| ext_trig_i | input | 1 | External level: 1 sample, 0 hold |
| ext_mode_i | input | 1 | 0 self-trigger, 1 external trigger |
| delay_cfg_i | input | DLY_W | Post-trigger delay D, in clock cycles (D+1 used) |
| conv_done_i | input | 1 | Conversion complete |
| rearm_i | input | 1 | Return from ready to sampling |
| sample_en_o | output | 1 | Storage write enable (0 = all switches open) |
| trig_out_o | output | NUM_CH | Registered discriminator copies |
| trig_dly_o | output | 1 | Pulse when the self-trigger delay expires |
| conv_start_o | output | 1 | Pulse starting conversion of all channels |
| data_ready_o | output | 1 | Converted data may be read |
| stop_ptr_o | output | PTR_W | Write pointer captured at the stop |

## Verification
Several properties are checked on every cycle:
- writing is off in the frozen states;
- the conversion start is a lone pulse;
- a delayed-trigger pulse is always preceded by the delay state;
- the countdown steps by one;
- the pointer moves only on enabled writes;
- the captured pointer holds between stops;
- the ready state persists until re-arm.

Only the bench's scenarios can show the rest:
- the exact stop cycle for a given delay, including D = 0 and D = 255;
- that a second hit during the countdown does not shift the stop;
- pointer wrap-around in the captured value;
- that re-arm is ignored during conversion and discriminators are ignored in external mode.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        ST_WRITE   = 2'd0,
        ST_DELAY   = 2'd1,
        ST_CONVERT = 2'd2,
        ST_READY   = 2'd3
    } acq_state_e;

endpackage

// File: rtl/acq_delay_timer.sv
module acq_delay_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] val_i,
    input  logic             run_i,
    output logic             expired_o
);
    logic [DLY_W-1:0] cnt_q;
    logic             arm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (run_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && $past(run_i) && !$past(load_i) && $past(cnt_q) != '0)
            |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/acq_wptr.sv
module acq_wptr #(
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             cap_i,
    output logic [PTR_W-1:0] stop_ptr_o
);
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] wr_ptr_nxt;
    logic             arm_q;

    assign wr_ptr_nxt = wr_ptr_q + PTR_W'(adv_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q   <= '0;
            stop_ptr_o <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_nxt;
            if (cap_i) stop_ptr_o <= wr_ptr_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    // R10
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !$past(adv_i)) |-> $stable(wr_ptr_q));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && !$past(cap_i)) |-> $stable(stop_ptr_o));

endmodule

// File: rtl/acq_trig_tap.sv
module acq_trig_tap #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_i,
    output logic [NUM_CH-1:0] hit_q_o
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hit_q_o[ch] <= 1'b0;
            else        hit_q_o[ch] <= hit_i[ch];
        end
    end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DLY_W  = 8,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] disc_i,
    input  logic              ext_trig_i,
    input  logic              ext_mode_i,
    input  logic [DLY_W-1:0]  delay_cfg_i,
    input  logic              conv_done_i,
    input  logic              rearm_i,
    output logic              sample_en_o,
    output logic [NUM_CH-1:0] trig_out_o,
    output logic              trig_dly_o,
    output logic              conv_start_o,
    output logic              data_ready_o,
    output logic [PTR_W-1:0]  stop_ptr_o
);
    acq_state_e state_q, state_d;
    logic       self_hit, ext_hold;
    logic       dly_load, dly_run, dly_expired;
    logic       stop_now;
    logic       arm_q;

    assign self_hit = !ext_mode_i && (|disc_i);
    assign ext_hold = ext_mode_i && !ext_trig_i;
    assign dly_load = (state_q == ST_WRITE) && self_hit;
    assign dly_run  = (state_q == ST_DELAY);
    assign stop_now = ((state_q == ST_WRITE) && ext_hold) ||
                      ((state_q == ST_DELAY) && dly_expired);

    acq_delay_timer #(.DLY_W(DLY_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (dly_load),
        .val_i     (delay_cfg_i),
        .run_i     (dly_run),
        .expired_o (dly_expired)
    );

    acq_wptr #(.PTR_W(PTR_W)) u_wptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (sample_en_o),
        .cap_i      (stop_now),
        .stop_ptr_o (stop_ptr_o)
    );

    acq_trig_tap #(.NUM_CH(NUM_CH)) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (disc_i),
        .hit_q_o (trig_out_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WRITE: begin
                if (self_hit)      state_d = ST_DELAY;
                else if (ext_hold) state_d = ST_CONVERT;
            end
            ST_DELAY:   if (dly_expired) state_d = ST_CONVERT;
            ST_CONVERT: if (conv_done_i) state_d = ST_READY;
            ST_READY:   if (rearm_i)     state_d = ST_WRITE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WRITE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_start_o <= 1'b0;
            trig_dly_o   <= 1'b0;
        end else begin
            conv_start_o <= stop_now;
            trig_dly_o   <= dly_run && dly_expired;
        end
    end

    always_comb begin
        sample_en_o  = 1'b0;
        data_ready_o = 1'b0;
        unique case (state_q)
            ST_WRITE:   sample_en_o  = ext_mode_i ? ext_trig_i : 1'b1;
            ST_DELAY:   sample_en_o  = 1'b1;
            ST_CONVERT: sample_en_o  = 1'b0;
            ST_READY:   data_ready_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT || state_q == ST_READY) |-> !sample_en_o);

    // R5
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    // R6
    dly_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q && trig_dly_o) |-> ($past(state_q) == ST_DELAY && conv_start_o));

    // R9
    ready_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && !rearm_i) |=> data_ready_o);

endmodule

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 4;
    localparam int DLY_W  = 8;
    localparam int PTR_W  = 8;
    localparam int DEPTH  = 1 << PTR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NUM_CH-1:0] disc;
    logic              ext_trig, ext_mode, conv_done, rearm;
    logic [DLY_W-1:0]  delay_cfg;
    logic              sample_en, trig_dly, conv_start, data_ready;
    logic [NUM_CH-1:0] trig_out;
    logic [PTR_W-1:0]  stop_ptr;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural reference: 0 write, 1 delay, 2 convert, 3 ready
    int m_st, m_cnt, m_wp, m_stop, m_tout;
    bit m_cs, m_td;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_sequencer #(.NUM_CH(NUM_CH), .DLY_W(DLY_W), .PTR_W(PTR_W)) u_acq_sequencer (
        .clk(clk), .rst_n(rst_n), .disc_i(disc), .ext_trig_i(ext_trig),
        .ext_mode_i(ext_mode), .delay_cfg_i(delay_cfg), .conv_done_i(conv_done),
        .rearm_i(rearm), .sample_en_o(sample_en), .trig_out_o(trig_out),
        .trig_dly_o(trig_dly), .conv_start_o(conv_start),
        .data_ready_o(data_ready), .stop_ptr_o(stop_ptr)
    );

    function automatic bit exp_se();
        if (m_st == 0) return ext_mode ? ext_trig : 1'b1;
        return (m_st == 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_wp = 0; m_stop = 0; m_tout = 0;
            m_cs = 0; m_td = 0;
        end else begin
            int nwp;
            nwp = (m_wp + (exp_se() ? 1 : 0)) % DEPTH;
            m_cs = 0; m_td = 0;
            m_tout = int'(disc);
            case (m_st)
                0: if (!ext_mode && disc != 0) begin m_st = 1; m_cnt = int'(delay_cfg); end
                   else if (ext_mode && !ext_trig) begin m_st = 2; m_cs = 1; m_stop = nwp; end
                1: if (m_cnt == 0) begin m_st = 2; m_cs = 1; m_td = 1; m_stop = nwp; end
                   else m_cnt = m_cnt - 1;
                2: if (conv_done) m_st = 3;
                default: if (rearm) m_st = 0;
            endcase
            m_wp = nwp;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            chk(sample_en == exp_se(), "R2/R4 sample_en", int'(sample_en), int'(exp_se()));
            chk(data_ready == (m_st == 3), "R8 data_ready", int'(data_ready), int'(m_st == 3));
            chk(conv_start == m_cs, "R5 conv_start", int'(conv_start), int'(m_cs));
            chk(trig_dly == m_td, "R6 trig_dly", int'(trig_dly), int'(m_td));
            chk(int'(trig_out) == m_tout, "R7 trig_out", int'(trig_out), m_tout);
            chk(int'(stop_ptr) == m_stop, "R10 stop_ptr", int'(stop_ptr), m_stop);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // self trigger with delay d; counts enabled cycles from the trigger cycle
    task automatic run_self(input int d, input logic [NUM_CH-1:0] ch);
        int cnt = 0;
        delay_cfg = DLY_W'(d);
        disc = ch;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!sample_en) break;
            cnt++;
            if (i == 1) disc = '0;
            if (i == 2 && d >= 3) disc = 4'b0001;
            if (i == 3) disc = '0;
        end
        disc = '0;
        chk(cnt == d + 2, (d >= 3) ? "R3 stop not moved by extra hit" : "R2 stop cycle",
            cnt, d + 2);
    endtask

    task automatic finish_conv();
        tick(3);
        conv_done = 1'b1;
        tick(1);
        conv_done = 1'b0;
        tick(2);
        if (ext_mode) ext_trig = 1'b1;
        rearm = 1'b1;
        tick(1);
        rearm = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; disc = '0; ext_trig = 1'b0; ext_mode = 1'b0;
        conv_done = 1'b0; rearm = 1'b0; delay_cfg = 8'd3;
        repeat (3) @(negedge clk);
        chk(sample_en == 1'b1, "R1 reset sample_en", int'(sample_en), 1);
        chk(data_ready == 1'b0 && conv_start == 1'b0 && trig_dly == 1'b0,
            "R1 reset flags", int'({data_ready, conv_start, trig_dly}), 0);
        chk(stop_ptr == '0 && trig_out == '0, "R1 reset ptr/tout",
            int'(stop_ptr) + int'(trig_out), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        tick(5);

        // self trigger, extra hit during the delay
        run_self(3, 4'b0100);
        tick(2);
        rearm = 1'b1; tick(1); rearm = 1'b0;
        @(negedge clk);
        chk(sample_en == 1'b0 && data_ready == 1'b0, "R9 rearm ignored in convert",
            int'({sample_en, data_ready}), 0);
        tick(1);
        conv_done = 1'b1; tick(1); conv_done = 1'b0;
        disc = 4'b1000; tick(3); disc = '0;
        @(negedge clk);
        chk(data_ready == 1'b1 && sample_en == 1'b0, "R3 hits ignored in ready",
            int'({data_ready, sample_en}), 2);
        tick(1);
        rearm = 1'b1; tick(1); rearm = 1'b0;
        @(negedge clk);
        chk(sample_en == 1'b1 && data_ready == 1'b0, "R9 rearm returns to write",
            int'({sample_en, data_ready}), 2);

        // minimum delay
        tick(4);
        run_self(0, 4'b0001);
        finish_conv();

        // external mode
        tick(2);
        ext_trig = 1'b1; ext_mode = 1'b1;
        tick(2);
        disc = 4'b1111;
        for (int k = 0; k < 3; k++) begin
            tick(1);
            @(negedge clk);
            chk(sample_en == 1'b1 && conv_start == 1'b0, "R11 hits ignored in ext mode",
                int'({sample_en, conv_start}), 2);
        end
        disc = '0;
        tick(3);
        ext_trig = 1'b0;
        @(negedge clk);
        chk(sample_en == 1'b0, "R4 immediate hold", int'(sample_en), 0);
        finish_conv();
        tick(2);
        ext_mode = 1'b0;

        // long run then maximum delay: pointer wraps
        tick(300);
        run_self(255, 4'b0010);
        finish_conv();
        tick(7);
        run_self(7, 4'b1000);
        finish_conv();
        tick(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule